// File: doc/BRIEF.md
# I/O Rail Deep Power-Down Sequencer

This block moves groups of I/O pad rails into and out of deep power-down under control of a small register bus. Software first arms the unit with a sample-enable bit and loads a settle time counted in bus-clock cycles. That settle time must be long enough to cover the pads' minimum of 200 ns. Software then writes a request word to one of two banks. The word carries a rail-select mask and a two-bit command. The sequencer waits for the settle time and then updates the per-rail power-down state of every selected rail together.

Each bank offers 30 selectable rails. The upper two bits of every request word hold the command code and never select a rail. The per-rail state can be read back through a status word in each bank, and it also drives one output wire per rail. A busy flag is shown on a port and in the control word. A command written while a transition is still settling is held in a one-entry slot. It starts on the cycle the current transition completes.

Top module: `pad_rail_dpd`

## Requirements
- R1: After reset every rail is out of deep power-down (`rail_dpd` all 0) and `busy` is 0. The control, settle and status words all read 0.
- R2: The registers sit at these word offsets: 0 control, 1 settle time (bits 15:0), 2 bank-0 request, 3 bank-0 status, 4 bank-1 request, 5 bank-1 status. In the control word, bit 0 is sample-enable and bit 31 is `busy`, which is read-only. A read strobe loads `rdata` at the clock edge, so the value is valid in the following cycle. Request offsets read as 0.
- R3: In a request word, bits 29:0 select rails and bits 31:30 hold the command. Code 2 enters deep power-down and code 1 leaves it.
- R4: Status bit i of bank 0 is rail i, and status bit i of bank 1 is rail 32+i. `rail_dpd[i]` carries rail i for i<30, and `rail_dpd[30+i]` carries rail 32+i. Status bits 31:30 always read 0.
- R5: An accepted command raises `busy` from the cycle after the write for exactly max(S,1) cycles, where S is the settle value. At the edge where `busy` falls, the selected rails update. No rail output changes at any other time.
- R6: Code 2 sets the status bits of the selected rails to 1. Code 1 clears them to 0. Rails that are not selected keep their state.
- R7: A request written while sample-enable is 0 changes no rail and does not raise `busy`.
- R8: A request with code 0 (idle) or code 3 changes no rail and does not raise `busy`.
- R9: A settle value of 0 behaves as a settle value of 1.
- R10: A command accepted while `busy` is high is held in one slot. A later held command replaces an earlier one. The held command starts at the completion edge of the current command, so `busy` stays high without a gap, and it takes the settle value in force when it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | Settle counter running |
| rail_dpd | output | 60 | Per-rail deep power-down state |

## Verification
A wrong settle counter shows up on the first command as a `busy` pulse of the wrong length. The bench measures that length against max(S,1) for every settle value from 0 to 5. A wrong mask, bank or command decode corrupts `rail_dpd` on the edge where `busy` falls. The corruption then stays visible in the status words. A broken hold slot shows as a gap in `busy`, as a lost command, or as a stale command that is replaced but applied anyway. Each of these appears within one settle period of the write that exposes it.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_LEAVE = 2'd1,
    CMD_ENTER = 2'd2,
    CMD_RSVD  = 2'd3
  } dpd_cmd_e;

  localparam int OFS_CTRL   = 0;
  localparam int OFS_SETTLE = 1;
  localparam int OFS_BANK0  = 2;
endpackage

// File: rtl/dpd_regif.sv
module dpd_regif #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int NUM_BANKS = 2,
  parameter int RAIL_W    = 30,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                smp_en,
  output logic [CNT_W-1:0]    settle,
  output logic                cmd_valid,
  output logic [BANK_W-1:0]   cmd_bank,
  output dpd_pkg::dpd_cmd_e   cmd_code,
  output logic [RAIL_W-1:0]   cmd_mask
);
  import dpd_pkg::*;

  logic             smp_q, smp_d, smp_we;
  logic [CNT_W-1:0] settle_q, settle_d, settle_we_val;
  logic             settle_we;
  logic             req_hit;
  int unsigned      widx;

  always_comb begin
    widx          = int'(addr) >> 1;
    smp_we        = wr_en && (addr == ADDR_W'(OFS_CTRL));
    settle_we     = wr_en && (addr == ADDR_W'(OFS_SETTLE));
    smp_d         = smp_we ? wdata[0] : smp_q;
    settle_we_val = wdata[CNT_W-1:0];
    settle_d      = settle_we ? settle_we_val : settle_q;
    req_hit       = wr_en && !addr[0] && (widx >= 1) && (widx <= NUM_BANKS);
    cmd_bank      = BANK_W'(widx - 1);
    cmd_code      = dpd_cmd_e'(wdata[DATA_W-1 -: 2]);
    cmd_mask      = wdata[RAIL_W-1:0];
    cmd_valid     = req_hit && smp_q &&
                    ((cmd_code == CMD_ENTER) || (cmd_code == CMD_LEAVE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= 1'b0;
      settle_q <= '0;
    end else begin
      smp_q    <= smp_d;
      settle_q <= settle_d;
    end
  end

  assign smp_en = smp_q;
  assign settle = settle_q;
endmodule

// File: rtl/dpd_sequencer.sv
module dpd_sequencer #(
  parameter int CNT_W   = 16,
  parameter int RAIL_W  = 30,
  parameter int BANK_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  settle,
  input  logic              cmd_valid,
  input  logic [BANK_W-1:0] cmd_bank,
  input  dpd_pkg::dpd_cmd_e cmd_code,
  input  logic [RAIL_W-1:0] cmd_mask,
  output logic              busy,
  output logic              done,
  output logic [BANK_W-1:0] done_bank,
  output dpd_pkg::dpd_cmd_e done_code,
  output logic [RAIL_W-1:0] done_mask
);
  import dpd_pkg::*;

  logic              act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, load_val;
  logic [BANK_W-1:0] cur_bank_q, cur_bank_d, pnd_bank_q, pnd_bank_d;
  dpd_cmd_e          cur_code_q, cur_code_d, pnd_code_q, pnd_code_d;
  logic [RAIL_W-1:0] cur_mask_q, cur_mask_d, pnd_mask_q, pnd_mask_d;
  logic              pnd_q, pnd_d;
  logic              fin;

  always_comb begin
    load_val   = (settle == '0) ? CNT_W'(1) : settle;
    fin        = act_q && (cnt_q == CNT_W'(1));
    act_d      = act_q;
    cnt_d      = act_q ? cnt_q - CNT_W'(1) : cnt_q;
    cur_bank_d = cur_bank_q;
    cur_code_d = cur_code_q;
    cur_mask_d = cur_mask_q;
    pnd_d      = pnd_q;
    pnd_bank_d = pnd_bank_q;
    pnd_code_d = pnd_code_q;
    pnd_mask_d = pnd_mask_q;

    if (fin) begin
      if (pnd_q) begin
        cur_bank_d = pnd_bank_q;
        cur_code_d = pnd_code_q;
        cur_mask_d = pnd_mask_q;
        cnt_d      = load_val;
        pnd_d      = 1'b0;
      end else begin
        act_d      = 1'b0;
      end
    end

    if (cmd_valid) begin
      if (!act_q || (fin && !pnd_q)) begin
        act_d      = 1'b1;
        cnt_d      = load_val;
        cur_bank_d = cmd_bank;
        cur_code_d = cmd_code;
        cur_mask_d = cmd_mask;
      end else begin
        pnd_d      = 1'b1;
        pnd_bank_d = cmd_bank;
        pnd_code_d = cmd_code;
        pnd_mask_d = cmd_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      cnt_q      <= '0;
      cur_bank_q <= '0;
      cur_code_q <= CMD_IDLE;
      cur_mask_q <= '0;
      pnd_q      <= 1'b0;
      pnd_bank_q <= '0;
      pnd_code_q <= CMD_IDLE;
      pnd_mask_q <= '0;
    end else begin
      act_q      <= act_d;
      cnt_q      <= cnt_d;
      cur_bank_q <= cur_bank_d;
      cur_code_q <= cur_code_d;
      cur_mask_q <= cur_mask_d;
      pnd_q      <= pnd_d;
      pnd_bank_q <= pnd_bank_d;
      pnd_code_q <= pnd_code_d;
      pnd_mask_q <= pnd_mask_d;
    end
  end

  assign busy      = act_q;
  assign done      = fin;
  assign done_bank = cur_bank_q;
  assign done_code = cur_code_q;
  assign done_mask = cur_mask_q;
endmodule

// File: rtl/dpd_status_bank.sv
module dpd_status_bank #(
  parameter int RAIL_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  dpd_pkg::dpd_cmd_e code,
  input  logic [RAIL_W-1:0] mask,
  output logic [RAIL_W-1:0] state
);
  import dpd_pkg::*;

  logic [RAIL_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (upd) begin
      if (code == CMD_ENTER) st_d = st_q | mask;
      else                   st_d = st_q & ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pad_rail_dpd.sv
module pad_rail_dpd #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int NUM_BANKS = 2,
  parameter int RAIL_W    = 30,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OUT_W    = NUM_BANKS * RAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic [OUT_W-1:0]  rail_dpd
);
  import dpd_pkg::*;

  logic              smp_en;
  logic [CNT_W-1:0]  settle;
  logic              cmd_valid;
  logic [BANK_W-1:0] cmd_bank;
  dpd_cmd_e          cmd_code;
  logic [RAIL_W-1:0] cmd_mask;
  logic              done;
  logic [BANK_W-1:0] done_bank;
  dpd_cmd_e          done_code;
  logic [RAIL_W-1:0] done_mask;
  logic [RAIL_W-1:0] bank_st [NUM_BANKS];
  logic [DATA_W-1:0] rd_mux, rdata_q;

  dpd_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .NUM_BANKS(NUM_BANKS), .RAIL_W(RAIL_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .smp_en(smp_en), .settle(settle), .cmd_valid(cmd_valid),
    .cmd_bank(cmd_bank), .cmd_code(cmd_code), .cmd_mask(cmd_mask)
  );

  dpd_sequencer #(
    .CNT_W(CNT_W), .RAIL_W(RAIL_W), .BANK_W(BANK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .settle(settle), .cmd_valid(cmd_valid),
    .cmd_bank(cmd_bank), .cmd_code(cmd_code), .cmd_mask(cmd_mask),
    .busy(busy), .done(done), .done_bank(done_bank),
    .done_code(done_code), .done_mask(done_mask)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dpd_status_bank #(.RAIL_W(RAIL_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .upd(done && (done_bank == BANK_W'(b))),
      .code(done_code), .mask(done_mask), .state(bank_st[b])
    );
    assign rail_dpd[b*RAIL_W +: RAIL_W] = bank_st[b];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_mux[0]        = smp_en;
      rd_mux[DATA_W-1] = busy;
    end else if (addr == ADDR_W'(OFS_SETTLE)) begin
      rd_mux[CNT_W-1:0] = settle;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(OFS_BANK0 + 2*b + 1))
        rd_mux[RAIL_W-1:0] = bank_st[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker #(
  parameter int ADDR_W  = 3,
  parameter int OUT_W   = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        code,
  input logic [1:0]        rdata_hi,
  input logic              busy,
  input logic              smp_en,
  input logic [OUT_W-1:0]  rail_dpd
);
  logic is_req, is_stat, live_code;

  assign is_req    = (addr == ADDR_W'(2)) || (addr == ADDR_W'(4));
  assign is_stat   = (addr == ADDR_W'(3)) || (addr == ADDR_W'(5));
  assign live_code = (code == 2'd1) || (code == 2'd2);

  // R5: rails move only on a completion edge
  assert_rail_move_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_dpd != $past(rail_dpd)) |-> $past(busy));

  // R5: an accepted command starts settling at once
  assert_accept_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_req && smp_en && live_code) |=> busy);

  // R7: disarmed writes start nothing
  assert_disarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_req && !smp_en && !busy) |=> !busy);

  // R8: idle and reserved codes start nothing
  assert_idle_code_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_req && !live_code && !busy) |=> !busy);

  // R4: status words never show the command bit positions
  assert_status_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_stat) |=> (rdata_hi == 2'b00));
endmodule

bind pad_rail_dpd dpd_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .code(wdata[DATA_W-1 -: 2]), .rdata_hi(rdata[DATA_W-1 -: 2]),
  .busy(busy), .smp_en(smp_en), .rail_dpd(rail_dpd)
);

// File: tb/sim_pad_rail_dpd.sv
`timescale 1ns/1ps
module sim_pad_rail_dpd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  logic [59:0] rail_dpd;
  logic [59:0] exp_dpd;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pad_rail_dpd u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .rail_dpd(rail_dpd));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [59:0] apply(input logic [59:0] s, input int bank,
                                        input int code, input logic [29:0] m);
    logic [59:0] full = 60'(m) << (30 * bank);
    return (code == 2) ? (s | full) : (code == 1) ? (s & ~full) : s;
  endfunction

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [29:0] m;
    int n;
    exp_dpd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rail_dpd == 0, "R1 rails", 64'(rail_dpd), 0);
    chk(busy == 0, "R1 busy", 64'(busy), 0);
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), rv);
      chk(rv == 0, "R1 reset read", 64'(rv), 0);
    end

    bus_wr(3'd0, 32'h1);
    bus_rd(3'd0, rv);
    chk(rv == 32'h1, "R2 ctrl readback", 64'(rv), 1);

    // sweep settle values, banks and both live commands
    for (int s = 0; s < 6; s++) begin
      bus_wr(3'd1, 32'(s));
      bus_rd(3'd1, rv);
      chk(rv == 32'(s), "R2 settle readback", 64'(rv), 64'(s));
      for (int bank = 0; bank < 2; bank++) begin
        for (int c = 2; c >= 1; c--) begin
          m = (30'h2AAAAAAA >> s) ^ (30'h1F << (s + 7 * bank));
          if (c == 1) m = m & 30'h0FF0FF0F;
          bus_wr(3'(2 + 2 * bank), {2'(c), m});
          busy_len(n);
          chk(n == ((s == 0) ? 1 : s), "R5 R9 busy length", 64'(n), 64'((s == 0) ? 1 : s));
          exp_dpd = apply(exp_dpd, bank, c, m);
          chk(rail_dpd == exp_dpd, "R6 rail state", 64'(rail_dpd), 64'(exp_dpd));
          bus_rd(3'(3 + 2 * bank), rv);
          chk(rv == {2'b00, exp_dpd[30*bank +: 30]}, "R3 R4 status word", 64'(rv),
              64'({2'b00, exp_dpd[30*bank +: 30]}));
        end
      end
    end

    // busy visible in control word
    bus_wr(3'd1, 32'd5);
    bus_wr(3'd2, {2'd2, 30'h3});
    bus_rd(3'd0, rv);
    chk(rv == 32'h8000_0001, "R2 busy bit", 64'(rv), 64'h8000_0001);
    busy_len(n);
    exp_dpd = apply(exp_dpd, 0, 2, 30'h3);

    // idle and reserved codes
    bus_wr(3'd4, {2'd0, 30'h3FFFFFFF});
    chk(busy == 0, "R8 idle busy", 64'(busy), 0);
    bus_wr(3'd2, {2'd3, 30'h3FFFFFFF});
    chk(busy == 0, "R8 reserved busy", 64'(busy), 0);
    repeat (8) @(negedge clk);
    chk(rail_dpd == exp_dpd, "R8 rails unchanged", 64'(rail_dpd), 64'(exp_dpd));

    // disarmed request
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd4, {2'd2, 30'h3FFFFFFF});
    chk(busy == 0, "R7 disarmed busy", 64'(busy), 0);
    repeat (8) @(negedge clk);
    chk(rail_dpd == exp_dpd, "R7 rails unchanged", 64'(rail_dpd), 64'(exp_dpd));
    bus_wr(3'd0, 32'h1);

    // held command chained behind a running one
    bus_wr(3'd1, 32'd3);
    bus_wr(3'd2, {2'd2, 30'h0000_0F00});
    bus_wr(3'd4, {2'd2, 30'h0000_00F0});
    chk(rail_dpd == exp_dpd, "R10 first not yet applied", 64'(rail_dpd), 64'(exp_dpd));
    busy_len(n);
    chk(n == 4, "R10 chained busy", 64'(n), 4);
    exp_dpd = apply(exp_dpd, 0, 2, 30'h0000_0F00);
    exp_dpd = apply(exp_dpd, 1, 2, 30'h0000_00F0);
    chk(rail_dpd == exp_dpd, "R10 both applied", 64'(rail_dpd), 64'(exp_dpd));

    // later held command replaces an earlier one
    bus_wr(3'd1, 32'd8);
    bus_wr(3'd2, {2'd1, 30'h0000_0F00});
    bus_wr(3'd4, {2'd2, 30'h0F00_0000});
    bus_wr(3'd4, {2'd1, 30'h0000_00F0});
    busy_len(n);
    chk(n == 12, "R10 replaced busy", 64'(n), 12);
    exp_dpd = apply(exp_dpd, 0, 1, 30'h0000_0F00);
    exp_dpd = apply(exp_dpd, 1, 1, 30'h0000_00F0);
    chk(rail_dpd == exp_dpd, "R10 replaced rails", 64'(rail_dpd), 64'(exp_dpd));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule